// File: doc/BRIEF.md
# Next-PC Select and Kill Logic

This block picks the address that the fetch stage reads next in a five-stage in-order pipeline with no delay slots, and raises kill signals that turn younger instructions into bubbles whenever control flow leaves the sequential path. Each kind of control transfer is resolved in its own stage. PC-relative jumps are resolved in decode and cost one bubble. Conditional branches and register-indirect jumps are resolved in execute and cost two bubbles. A trap redirect, presented by the commit logic, overrides all of them.

The logic is purely combinational. It sits between the pipeline registers and the fetch PC register. The pipeline applies `kill_fetch` to the instruction now in fetch and `kill_decode` to the instruction now in decode, so that neither changes architectural state.

Top module: `next_pc_ctrl`

## Requirements
- R1: With no trap, no decode jump, no register jump and no taken branch, `next_pc` equals `fetch_pc + INST_BYTES` (4 by default), and both kill outputs are 0.
- R2: A decode jump (`dec_jump`=1) with no execute redirect and no trap gives `next_pc = dec_pc + sign-extended dec_off`, `kill_fetch`=1 and `kill_decode`=0.
- R3: A taken branch (`exe_branch`=1, `exe_taken`=1) with `exe_jreg`=0 and no trap gives `next_pc = exe_pc + sign-extended exe_off`, and both kill outputs are 1.
- R4: A not-taken branch (`exe_branch`=1, `exe_taken`=0) redirects nothing and kills nothing; the result is the same as with `exe_branch`=0.
- R5: A register jump (`exe_jreg`=1) with no trap gives `next_pc = exe_reg + sign-extended exe_off`, and both kill outputs are 1. When `exe_jreg` is 1, the branch inputs have no effect.
- R6: An execute redirect (R3 or R5) wins over a simultaneous decode jump, and the decode instruction is killed.
- R7: `trap_req`=1 gives `next_pc = trap_vec` and both kill outputs 1, whatever the other inputs are.
- R8: All target sums wrap modulo 2^XLEN.
- R9: `kill_decode` is never 1 while `kill_fetch` is 0.
- R10: With `JR_CLR_LSB`=1 (the default), bit 0 of a register-jump target is forced to 0. No other target is changed this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_pc | input | XLEN | PC of the instruction in fetch |
| dec_pc | input | XLEN | PC of the instruction in decode |
| dec_jump | input | 1 | Decode holds a PC-relative jump |
| dec_off | input | DOFF_W | Signed jump offset from decode |
| exe_pc | input | XLEN | PC of the instruction in execute |
| exe_branch | input | 1 | Execute holds a conditional branch |
| exe_taken | input | 1 | Branch condition result |
| exe_jreg | input | 1 | Execute holds a register-indirect jump |
| exe_reg | input | XLEN | Register value read for the register jump |
| exe_off | input | EOFF_W | Signed offset for a branch or register jump |
| trap_req | input | 1 | Trap redirect from the commit point |
| trap_vec | input | XLEN | Handler address for a trap |
| next_pc | output | XLEN | Address to fetch next |
| kill_fetch | output | 1 | Turn the fetch-stage instruction into a bubble |
| kill_decode | output | 1 | Turn the decode-stage instruction into a bubble |

## Verification
The bench uses an 8-bit configuration with 6-bit offsets and sweeps all 32 combinations of the five control flags (trap, register jump, branch, taken, decode jump). Each combination is tried against sixteen operand sets that include negative offsets and odd register values. The flag sweep separates the priority order and the bubble count of each source. The operand sets separate the targets from one another: a wrong base or a missed sign extension changes the address, and the odd register values expose a missing clear of bit 0. Directed cases at the top of the address space check wraparound for both the sequential and the jump paths.

// File: rtl/next_pc_pkg.sv
// Package: shared types for next-PC selection.
// Assumes: at most one redirect source is chosen per cycle.
package next_pc_pkg;

    // Which source drives the next fetch address, ordered by priority (highest last).
    typedef enum logic [2:0] {
        SRC_SEQ   = 3'd0,
        SRC_DJMP  = 3'd1,
        SRC_BR    = 3'd2,
        SRC_JREG  = 3'd3,
        SRC_TRAP  = 3'd4
    } redir_src_e;

    // Kill pair carried between the arbiter and the top.
    typedef struct packed {
        logic fetch;
        logic decode;
    } kill_t;

endpackage

// File: rtl/pcs_target_gen.sv
// Module: pcs_target_gen
// Adds a signed offset of OFF_W bits to an XLEN-bit base and wraps modulo 2^XLEN.
// Can force bit 0 of the sum to zero when CLR_LSB is set.
// Assumes: OFF_W >= 1. An offset wider than XLEN is truncated.
module pcs_target_gen #(
    parameter int XLEN    = 32,
    parameter int OFF_W   = 21,
    parameter bit CLR_LSB = 1'b0
) (
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  target
);
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] sum;

    // Widen the offset to XLEN bits, by sign extension or by truncation.
    generate
        if (OFF_W < XLEN) begin : g_sext
            localparam int EXT_W = XLEN - OFF_W;
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[XLEN-1:0];
        end
    endgenerate

    // Add the offset to the base; the carry out of the top bit is dropped.
    always_comb begin
        sum = base + off_ext;
    end

    // Apply the optional clear of bit 0.
    generate
        if (CLR_LSB) begin : g_clr
            assign target = {sum[XLEN-1:1], 1'b0};
        end else begin : g_keep
            assign target = sum;
        end
    endgenerate
endmodule

// File: rtl/pcs_redirect_arb.sv
// Module: pcs_redirect_arb
// Priority arbiter for the redirect sources. It picks one source and the kill pair that goes with it.
// Order: trap > register jump > taken branch > decode jump > sequential.
// Assumes: the flags are valid for the current cycle; no further qualification is applied.
module pcs_redirect_arb
    import next_pc_pkg::*;
(
    input  logic       trap_req,
    input  logic       exe_jreg,
    input  logic       exe_branch,
    input  logic       exe_taken,
    input  logic       dec_jump,
    output redir_src_e src,
    output kill_t      kills
);
    logic br_redirect;

    // A branch redirects only when its condition holds.
    always_comb begin
        br_redirect = exe_branch & exe_taken;
    end

    // Priority selection of the redirect source.
    always_comb begin
        if (trap_req)         src = SRC_TRAP;
        else if (exe_jreg)    src = SRC_JREG;
        else if (br_redirect) src = SRC_BR;
        else if (dec_jump)    src = SRC_DJMP;
        else                  src = SRC_SEQ;
    end

    // Bubble count per source: execute and trap redirects kill two stages, decode kills one.
    always_comb begin
        unique case (src)
            SRC_TRAP, SRC_JREG, SRC_BR: kills = '{fetch: 1'b1, decode: 1'b1};
            SRC_DJMP:                   kills = '{fetch: 1'b1, decode: 1'b0};
            default:                    kills = '{fetch: 1'b0, decode: 1'b0};
        endcase
    end
endmodule

// File: rtl/next_pc_ctrl.sv
// Module: next_pc_ctrl
// Chooses the next fetch PC and the kill signals for the fetch and decode stages in a
// five-stage pipeline without delay slots. Purely combinational.
// Assumes: the caller registers next_pc into the fetch PC and applies the kills this cycle.
module next_pc_ctrl
    import next_pc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int DOFF_W     = 21,
    parameter int EOFF_W     = 13,
    parameter int INST_BYTES = 4,
    parameter bit JR_CLR_LSB = 1'b1
) (
    input  logic [XLEN-1:0]   fetch_pc,
    input  logic [XLEN-1:0]   dec_pc,
    input  logic              dec_jump,
    input  logic [DOFF_W-1:0] dec_off,
    input  logic [XLEN-1:0]   exe_pc,
    input  logic              exe_branch,
    input  logic              exe_taken,
    input  logic              exe_jreg,
    input  logic [XLEN-1:0]   exe_reg,
    input  logic [EOFF_W-1:0] exe_off,
    input  logic              trap_req,
    input  logic [XLEN-1:0]   trap_vec,
    output logic [XLEN-1:0]   next_pc,
    output logic              kill_fetch,
    output logic              kill_decode
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INST_BYTES);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] djmp_tgt;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jreg_tgt;
    redir_src_e      src;
    kill_t           kills;

    // Sequential successor of the fetch PC.
    always_comb begin
        seq_pc = fetch_pc + STEP;
    end

    pcs_target_gen #(.XLEN(XLEN), .OFF_W(DOFF_W), .CLR_LSB(1'b0)) i_djmp_tgt (
        .base(dec_pc), .off(dec_off), .target(djmp_tgt)
    );

    pcs_target_gen #(.XLEN(XLEN), .OFF_W(EOFF_W), .CLR_LSB(1'b0)) i_br_tgt (
        .base(exe_pc), .off(exe_off), .target(br_tgt)
    );

    pcs_target_gen #(.XLEN(XLEN), .OFF_W(EOFF_W), .CLR_LSB(JR_CLR_LSB)) i_jreg_tgt (
        .base(exe_reg), .off(exe_off), .target(jreg_tgt)
    );

    pcs_redirect_arb i_arb (
        .trap_req  (trap_req),
        .exe_jreg  (exe_jreg),
        .exe_branch(exe_branch),
        .exe_taken (exe_taken),
        .dec_jump  (dec_jump),
        .src       (src),
        .kills     (kills)
    );

    // Steer the address of the chosen source onto next_pc.
    always_comb begin
        unique case (src)
            SRC_TRAP: next_pc = trap_vec;
            SRC_JREG: next_pc = jreg_tgt;
            SRC_BR:   next_pc = br_tgt;
            SRC_DJMP: next_pc = djmp_tgt;
            default:  next_pc = seq_pc;
        endcase
    end

    // Drive the kill outputs.
    always_comb begin
        kill_fetch  = kills.fetch;
        kill_decode = kills.decode;
    end
endmodule

// File: rtl/next_pc_ctrl_chk.sv
// Module: next_pc_ctrl_chk
// Checker bound to next_pc_ctrl. It relates the port-level redirect inputs to the kills and the next PC.
// Assumes: combinational block, so the checks are immediate and evaluated whenever a port changes.
module next_pc_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic [XLEN-1:0] fetch_pc,
    input logic            dec_jump,
    input logic            exe_branch,
    input logic            exe_taken,
    input logic            exe_jreg,
    input logic            trap_req,
    input logic [XLEN-1:0] trap_vec,
    input logic [XLEN-1:0] next_pc,
    input logic            kill_fetch,
    input logic            kill_decode
);
    logic exe_redir;
    logic any_redir;

    // Summarise the redirect requests seen at the ports.
    always_comb begin
        exe_redir = exe_jreg | (exe_branch & exe_taken);
        any_redir = trap_req | exe_redir | dec_jump;
    end

    // Port relations that must hold for any input combination.
    always_comb begin
        assert_kill_order_R9: assert (!kill_decode || kill_fetch);
        if (trap_req) begin
            assert_trap_wins_R7: assert (next_pc == trap_vec && kill_fetch && kill_decode);
        end
        if (!trap_req && exe_redir) begin
            assert_exe_two_bubbles_R6: assert (kill_fetch && kill_decode);
        end
        if (!trap_req && !exe_redir && dec_jump) begin
            assert_dec_one_bubble_R2: assert (kill_fetch && !kill_decode);
        end
        if (!any_redir) begin
            assert_seq_no_kill_R1: assert (!kill_fetch && !kill_decode && next_pc != fetch_pc);
        end
        if (exe_branch && !exe_taken && !exe_jreg && !trap_req && !dec_jump) begin
            assert_not_taken_quiet_R4: assert (!kill_fetch && !kill_decode);
        end
    end
endmodule

bind next_pc_ctrl next_pc_ctrl_chk #(.XLEN(XLEN)) i_next_pc_ctrl_chk (
    .fetch_pc   (fetch_pc),
    .dec_jump   (dec_jump),
    .exe_branch (exe_branch),
    .exe_taken  (exe_taken),
    .exe_jreg   (exe_jreg),
    .trap_req   (trap_req),
    .trap_vec   (trap_vec),
    .next_pc    (next_pc),
    .kill_fetch (kill_fetch),
    .kill_decode(kill_decode)
);

// File: tb/test_next_pc_ctrl.sv
// Bench for next_pc_ctrl: an 8-bit configuration with 6-bit offsets.
// Sweeps every flag combination against a set of operands and computes the expected results arithmetically.
module test_next_pc_ctrl;
    localparam int XLEN = 8;
    localparam int OW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [XLEN-1:0] fetch_pc = '0, dec_pc = '0, exe_pc = '0, exe_reg = '0, trap_vec = '0;
    logic [OW-1:0]   dec_off = '0, exe_off = '0;
    logic dec_jump = 1'b0, exe_branch = 1'b0, exe_taken = 1'b0, exe_jreg = 1'b0, trap_req = 1'b0;
    logic [XLEN-1:0] next_pc;
    logic kill_fetch, kill_decode;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    next_pc_ctrl #(.XLEN(XLEN), .DOFF_W(OW), .EOFF_W(OW), .INST_BYTES(4), .JR_CLR_LSB(1'b1)) i_next_pc_ctrl (
        .fetch_pc(fetch_pc), .dec_pc(dec_pc), .dec_jump(dec_jump), .dec_off(dec_off),
        .exe_pc(exe_pc), .exe_branch(exe_branch), .exe_taken(exe_taken), .exe_jreg(exe_jreg),
        .exe_reg(exe_reg), .exe_off(exe_off), .trap_req(trap_req), .trap_vec(trap_vec),
        .next_pc(next_pc), .kill_fetch(kill_fetch), .kill_decode(kill_decode)
    );

    // Sign-extend a 6-bit offset to the address width.
    function automatic logic [XLEN-1:0] sx(input logic [OW-1:0] o);
        return {{(XLEN-OW){o[OW-1]}}, o};
    endfunction

    // Compare the outputs with the expected tuple and log a failure with the requirement tag.
    task automatic check(input string req, input logic [XLEN-1:0] epc, input logic ekf, input logic ekd);
        checks++;
        if (next_pc !== epc || kill_fetch !== ekf || kill_decode !== ekd) begin
            fails++;
            $display("FAIL %s: got pc=%02h kf=%0b kd=%0b expected pc=%02h kf=%0b kd=%0b",
                     req, next_pc, kill_fetch, kill_decode, epc, ekf, ekd);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: got cycles=%0d expected < 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    logic [XLEN-1:0] e_pc;
    logic e_kf, e_kd;
    string tag;

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle: sequential fetch (R1).
        fetch_pc = 8'h10;
        @(negedge clk);
        check("R1 idle", 8'h14, 1'b0, 1'b0);

        // Flag sweep x operand sets.
        for (int v = 0; v < 16; v++) begin
            for (int f = 0; f < 32; f++) begin
                @(posedge clk);
                fetch_pc = 8'(v * 37 + 3);
                dec_pc   = 8'(v * 53 + 11);
                exe_pc   = 8'(v * 29 + 200);
                exe_reg  = 8'(v * 71 + 1);          // odd and even values (R10)
                trap_vec = 8'(v * 17 + 128);
                dec_off  = 6'(v * 5 + 33);          // negative and positive
                exe_off  = 6'(v * 11 + 40);
                trap_req   = f[4];
                exe_jreg   = f[3];
                exe_branch = f[2];
                exe_taken  = f[1];
                dec_jump   = f[0];
                if (trap_req) begin
                    e_pc = trap_vec; e_kf = 1; e_kd = 1; tag = "R7 trap";
                end else if (exe_jreg) begin
                    e_pc = (exe_reg + sx(exe_off)) & 8'hFE; e_kf = 1; e_kd = 1; tag = "R5/R10/R6 jreg";
                end else if (exe_branch && exe_taken) begin
                    e_pc = exe_pc + sx(exe_off); e_kf = 1; e_kd = 1; tag = "R3/R6 branch";
                end else if (dec_jump) begin
                    e_pc = dec_pc + sx(dec_off); e_kf = 1; e_kd = 0; tag = "R2/R4 djump";
                end else begin
                    e_pc = fetch_pc + 8'd4; e_kf = 0; e_kd = 0; tag = "R1/R4 seq";
                end
                @(negedge clk);
                check(tag, e_pc, e_kf, e_kd);
                checks++;   // R9 ordering on every vector
                if (kill_decode && !kill_fetch) begin
                    fails++;
                    $display("FAIL R9: got kf=0 kd=1 expected kd implies kf");
                end
            end
        end

        // Wraparound at the top of the address space (R8).
        @(posedge clk);
        {trap_req, exe_jreg, exe_branch, exe_taken, dec_jump} = 5'b0;
        fetch_pc = 8'hFE;
        @(negedge clk);
        check("R8 seq wrap", 8'h02, 1'b0, 1'b0);
        @(posedge clk);
        dec_jump = 1'b1; dec_pc = 8'hF8; dec_off = 6'h1F;
        @(negedge clk);
        check("R8 djump wrap", 8'h17, 1'b1, 1'b0);
        @(posedge clk);
        dec_jump = 1'b0; exe_branch = 1'b1; exe_taken = 1'b1; exe_pc = 8'h04; exe_off = 6'h38;
        @(negedge clk);
        check("R8 branch wrap down", 8'hFC, 1'b1, 1'b1);
        // A not-taken branch leaves fetch sequential (R4).
        @(posedge clk);
        exe_taken = 1'b0; fetch_pc = 8'h40;
        @(negedge clk);
        check("R4 not taken", 8'h44, 1'b0, 1'b0);
        // Odd register-jump target gets bit 0 cleared; a branch to an odd address keeps it (R10).
        @(posedge clk);
        exe_branch = 1'b0; exe_jreg = 1'b1; exe_reg = 8'h21; exe_off = 6'h02;
        @(negedge clk);
        check("R10 jreg lsb", 8'h22, 1'b1, 1'b1);
        @(posedge clk);
        exe_jreg = 1'b0; exe_branch = 1'b1; exe_taken = 1'b1; exe_pc = 8'h21; exe_off = 6'h02;
        @(negedge clk);
        check("R10 branch keeps lsb", 8'h23, 1'b1, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule